// File: doc/BRIEF.md
# APB Protocol Rule Watcher

This block sits beside an APB bus as a passive observer. Every clock it samples the completer select vector and the shared bus lines: enable, direction, address, write data, ready and slave error. It judges each cycle against the two-phase transfer rules. Five rule classes are tracked, one for each step of a transfer: a request with more than one completer selected, an access that starts without a setup cycle, bus fields that drift during a stalled access, a ready that drops after it was already given, and an error strobe outside a completing beat. Transfer contents are never decoded.

Each rule class has its own sticky flag. A one-cycle pulse marks the cycle after each violating cycle is sampled. A 3-bit code records the first class seen. The flags and the code clear only on the active-low synchronous reset.

Internally a four-state tracker records what the previous cycle was. `PH_IDLE` means no completer was selected. `PH_SETUP` means a completer was selected with enable low. `PH_WAIT` means an access cycle with ready low. `PH_DONE` means a completing access cycle. The tracker moves between states on the current cycle alone:
- no select goes to `PH_IDLE`;
- select with enable low goes to `PH_SETUP`;
- select with enable high and ready low goes to `PH_WAIT`;
- select with enable and ready high goes to `PH_DONE`.

The rule logic judges the current cycle against that state.

Top module: `apb_rule_watch`

## Requirements
- R1: After a clock edge with `rst_n` low, `viol_flags` is 0, `viol_pulse` is 0 and `viol_first` is 0.
- R2: Enable high in a cycle whose previous cycle was neither a setup cycle (some select high, enable low) nor a waiting access (select and enable high, ready low) sets flag bit 0, code 1. A cycle that follows a completion with ready low is the exception, and is handled by R4 instead. Enable high while all select lines are low also sets flag bit 0, code 1.
- R3: In an access cycle following a waiting access cycle, any change of address, direction or write data relative to the previous cycle sets flag bit 1, code 2.
- R4: An access cycle (select and enable high) with ready low that directly follows a completing cycle sets flag bit 2, code 3.
- R5: An access cycle with slave error high and ready low sets flag bit 3, code 4. Slave error high together with ready high is a legal error response and is not flagged.
- R6: Two or more select lines high in the same cycle set flag bit 4, code 5.
- R7: Legal traffic raises nothing. This covers zero-wait and multi-wait reads and writes, idle gaps, completions with an error response, and a completion followed directly by a new setup cycle with select held high.
- R8: A set flag stays set, whatever traffic follows, until reset.
- R9: `viol_pulse` is high for exactly the cycle after each clock edge that samples a violating cycle, and low otherwise.
- R10: `viol_first` holds the code of the earliest violation until reset. When several rule classes fire in the same cycle, all their flags are set and the code takes the lowest of their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | N_SEL | Completer select lines, one-hot expected |
| bus_enable | input | 1 | Access-phase enable |
| bus_write | input | 1 | Direction, high for write |
| bus_addr | input | ADDR_W | Transfer address |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | input | 1 | Completer ready |
| bus_slverr | input | 1 | Completer error strobe |
| viol_flags | output | 5 | Sticky flags; bit k is the rule with code k+1 |
| viol_pulse | output | 1 | High the cycle after a violating cycle is sampled |
| viol_first | output | 3 | Code of the first violation, 0 when none |

## Verification
The embedded assertions assume that every bus input is a known 0 or 1 at each rising edge once reset is released. They also assume the bench holds reset across at least one edge at start-up, so the phase tracker begins in `PH_IDLE`. The stimulus changes inputs only on falling edges and starts every scenario from a reset. Both legal and deliberately broken sequences are driven through the same cycle task. The bench's reference model reasons only from the rules above, so illegal patterns never reach the design in a form the assumptions exclude.

// File: rtl/apb_rw_pkg.sv
package apb_rw_pkg;

    // Classification of the previous bus cycle
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    localparam int NRULE  = 5;
    localparam int CODE_W = 3;

    // Bit positions in the rule vector; code reported is position + 1
    localparam int RULE_NOSETUP = 0;
    localparam int RULE_DRIFT   = 1;
    localparam int RULE_GLITCH  = 2;
    localparam int RULE_MISQUAL = 3;
    localparam int RULE_MULTI   = 4;

    typedef logic [NRULE-1:0]  rule_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    function automatic code_t rule_code(input int idx);
        return code_t'(idx + 1);
    endfunction

endpackage

// File: rtl/apb_rw_phase.sv
module apb_rw_phase
    import apb_rw_pkg::*;
#(
    parameter int N_SEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SEL-1:0] sel,
    input  logic             enable,
    input  logic             ready,
    output phase_e           phase_q
);

    phase_e phase_d;
    logic   sel_any;

    assign sel_any = |sel;

    // Next-state: the state names what the current cycle was
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE, PH_SETUP, PH_WAIT, PH_DONE: begin
                if (!sel_any) begin
                    phase_d = PH_IDLE;
                end else if (!enable) begin
                    phase_d = PH_SETUP;
                end else if (ready) begin
                    phase_d = PH_DONE;
                end else begin
                    phase_d = PH_WAIT;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R2
    setup_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |-> !$past(enable));

    // R4
    done_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |-> $past(ready));

endmodule

// File: rtl/apb_rw_rules.sv
module apb_rw_rules
    import apb_rw_pkg::*;
#(
    parameter int N_SEL  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_q,
    input  logic [N_SEL-1:0]  sel,
    input  logic              enable,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    input  logic              slverr,
    output rule_vec_t         hit
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;

    logic sel_any;
    logic active;
    logic no_setup;
    logic drift;
    logic glitch;
    logic misqual;
    logic clash;

    // Previous-cycle copy of the fields that must hold during an access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else begin
            addr_q  <= addr;
            wdata_q <= wdata;
            write_q <= write;
        end
    end

    // Multiple-select detect: ripple of "a lower line is already high"
    logic [N_SEL:0] seen;
    logic [N_SEL-1:0] pair;
    assign seen[0] = 1'b0;
    generate
        for (genvar i = 0; i < N_SEL; i++) begin : g_sel
            assign pair[i]   = sel[i] & seen[i];
            assign seen[i+1] = seen[i] | sel[i];
        end
    endgenerate
    assign clash = |pair;

    assign sel_any = |sel;
    assign active  = sel_any & enable;
    assign misqual = active & slverr & ~ready;

    always_comb begin
        no_setup = 1'b0;
        drift    = 1'b0;
        glitch   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                no_setup = enable;
            end
            PH_SETUP: begin
                no_setup = enable & ~sel_any;
            end
            PH_WAIT: begin
                no_setup = enable & ~sel_any;
                drift    = active & ((addr != addr_q) |
                                     (write != write_q) |
                                     (wdata != wdata_q));
            end
            PH_DONE: begin
                no_setup = enable & (~sel_any | ready);
                glitch   = active & ~ready;
            end
            default: begin
                no_setup = 1'b0;
            end
        endcase
    end

    always_comb begin
        hit               = '0;
        hit[RULE_NOSETUP] = no_setup;
        hit[RULE_DRIFT]   = drift;
        hit[RULE_GLITCH]  = glitch;
        hit[RULE_MISQUAL] = misqual;
        hit[RULE_MULTI]   = clash;
    end

    // R6
    onehot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) |-> !hit[RULE_MULTI]);

    // R7
    setup_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_SETUP) && sel_any && enable) |-> !hit[RULE_NOSETUP]);

endmodule

// File: rtl/apb_rw_report.sv
module apb_rw_report
    import apb_rw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rule_vec_t hit,
    output rule_vec_t flags_q,
    output logic      pulse_q,
    output code_t     code_q
);

    code_t lowest;

    // Lowest-numbered rule among those firing this cycle
    always_comb begin
        lowest = '0;
        for (int k = NRULE - 1; k >= 0; k--) begin
            if (hit[k]) begin
                lowest = rule_code(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            pulse_q <= 1'b0;
            code_q  <= '0;
        end else begin
            flags_q <= flags_q | hit;
            pulse_q <= |hit;
            if (code_q == '0) begin
                code_q <= lowest;
            end
        end
    end

    // R8
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R10
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0) |=> $stable(code_q));

    // R9
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (flags_q != '0));

    // R10
    first_flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0) == (flags_q != '0));

endmodule

// File: rtl/apb_rule_watch.sv
module apb_rule_watch
    import apb_rw_pkg::*;
#(
    parameter int N_SEL  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SEL-1:0]  bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_slverr,
    output logic [4:0]        viol_flags,
    output logic              viol_pulse,
    output logic [2:0]        viol_first
);

    phase_e    phase_q;
    rule_vec_t hit;
    rule_vec_t flags_q;
    code_t     code_q;

    apb_rw_phase #(.N_SEL(N_SEL)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .enable  (bus_enable),
        .ready   (bus_ready),
        .phase_q (phase_q)
    );

    apb_rw_rules #(.N_SEL(N_SEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rules (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q),
        .sel     (bus_sel),
        .enable  (bus_enable),
        .write   (bus_write),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ready   (bus_ready),
        .slverr  (bus_slverr),
        .hit     (hit)
    );

    apb_rw_report i_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .flags_q (flags_q),
        .pulse_q (viol_pulse),
        .code_q  (code_q)
    );

    assign viol_flags = flags_q;
    assign viol_first = code_q;

endmodule

// File: tb/test_apb_rule_watch.sv
`timescale 1ns/1ps
module test_apb_rule_watch;

    localparam int NS = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sel = '0;
    logic          en = 1'b0, wr = 1'b0, rdy = 1'b0, err = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [4:0]    flags;
    logic          pulse;
    logic [2:0]    first;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    cmp_on  = 1'b0;

    always #2.5 clk = ~clk;

    apb_rule_watch #(.N_SEL(NS), .ADDR_W(AW), .DATA_W(DW)) i_apb_rule_watch (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en),
        .bus_write(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_ready(rdy), .bus_slverr(err),
        .viol_flags(flags), .viol_pulse(pulse), .viol_first(first)
    );

    // ---------------- behavioural reference model ----------------
    bit            m_any, m_en, m_rdy;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    bit            m_wr;
    logic [4:0]    e_flags = '0;
    bit            e_pulse = 1'b0;
    logic [2:0]    e_first = '0;

    always @(posedge clk) begin
        logic [4:0] v;
        bit any, was_setup, was_wait, was_done;
        if (!rst_n) begin
            e_flags = '0; e_pulse = 1'b0; e_first = '0;
            m_any = 1'b0; m_en = 1'b0; m_rdy = 1'b0;
        end else begin
            any       = (sel != '0);
            was_setup = m_any && !m_en;
            was_wait  = m_any && m_en && !m_rdy;
            was_done  = m_any && m_en && m_rdy;
            v = '0;
            if (en && (!any || !(was_setup || was_wait || (was_done && !rdy))))
                v[0] = 1'b1;
            if (was_wait && any && en &&
                (addr != m_addr || wr != m_wr || wdata != m_wdata))
                v[1] = 1'b1;
            if (was_done && any && en && !rdy) v[2] = 1'b1;
            if (any && en && err && !rdy)      v[3] = 1'b1;
            if ($countones(sel) > 1)           v[4] = 1'b1;
            e_flags = e_flags | v;
            e_pulse = (v != '0);
            if (e_first == 0) begin
                for (int k = 4; k >= 0; k--) if (v[k]) e_first = 3'(k + 1);
            end
            m_any = any; m_en = en; m_rdy = rdy;
        end
        m_addr = addr; m_wdata = wdata; m_wr = wr;
    end

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "model flags", int'(flags), int'(e_flags));
            chk(cur_req, "model pulse", int'(pulse), int'(e_pulse));
            chk(cur_req, "model first", int'(first), int'(e_first));
        end
    end

    // drive one cycle (called at a falling edge), return at next falling edge
    task automatic cyc(input logic [NS-1:0] s, input logic e, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic r, input logic x);
        sel = s; en = e; wr = w; addr = a; wdata = d; rdy = r; err = x;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, 0, 0, '0, '0, 0, 0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // legal transfer: setup, waits, completion
    task automatic xfer(input logic [NS-1:0] s, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int waits, input logic x);
        cyc(s, 0, w, a, d, 0, 0);
        for (int i = 0; i < waits; i++) cyc(s, 1, w, a, d, 0, 0);
        cyc(s, 1, w, a, d, 1, x);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cmp_on = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk("R1", "flags after reset", flags, 0);
        chk("R1", "pulse after reset", pulse, 0);
        chk("R1", "first after reset", first, 0);

        // R7 legal traffic
        cur_req = "R7";
        xfer(4'b0001, 0, 12'h010, 0, 0, 0);
        xfer(4'b0010, 1, 12'h020, 32'hCAFE0001, 2, 0);
        idle(1);
        xfer(4'b0100, 0, 12'h030, 0, 1, 1);
        xfer(4'b0100, 1, 12'h034, 32'h5, 0, 0);
        xfer(4'b0100, 0, 12'h038, 0, 3, 0);
        idle(2);
        chk("R7", "flags after legal traffic", flags, 0);
        chk("R7", "pulse after legal traffic", pulse, 0);

        // R2 missing setup from idle
        cur_req = "R2";
        cyc(4'b0001, 1, 0, 12'h040, 0, 1, 0);
        chk("R2", "flags no setup", flags, 5'b00001);
        chk("R2", "first no setup", first, 1);
        idle(1);
        do_reset();
        cyc(4'b0000, 1, 0, 12'h000, 0, 0, 0);
        chk("R2", "enable with no select", flags, 5'b00001);
        idle(1);

        // R3 stability
        do_reset();
        cur_req = "R3";
        cyc(4'b0010, 0, 1, 12'h100, 32'h11, 0, 0);
        cyc(4'b0010, 1, 1, 12'h100, 32'h11, 0, 0);
        cyc(4'b0010, 1, 1, 12'h104, 32'h11, 1, 0);
        chk("R3", "flags addr drift", flags, 5'b00010);
        chk("R3", "first addr drift", first, 2);
        do_reset();
        cyc(4'b0010, 0, 1, 12'h100, 32'h11, 0, 0);
        cyc(4'b0010, 1, 1, 12'h100, 32'h11, 0, 0);
        cyc(4'b0010, 1, 1, 12'h100, 32'h12, 0, 0);
        chk("R3", "flags wdata drift", flags, 5'b00010);
        cyc(4'b0010, 1, 1, 12'h100, 32'h12, 1, 0);
        idle(1);

        // R4 ready glitch
        do_reset();
        cur_req = "R4";
        cyc(4'b1000, 0, 0, 12'h200, 0, 0, 0);
        cyc(4'b1000, 1, 0, 12'h200, 0, 1, 0);
        cyc(4'b1000, 1, 0, 12'h200, 0, 0, 0);
        chk("R4", "flags glitch", flags, 5'b00100);
        chk("R4", "first glitch", first, 3);
        idle(1);

        // R5 misqualified error, then legal error response
        do_reset();
        cur_req = "R5";
        cyc(4'b0001, 0, 0, 12'h300, 0, 0, 0);
        cyc(4'b0001, 1, 0, 12'h300, 0, 0, 1);
        chk("R5", "flags misqualified", flags, 5'b01000);
        chk("R5", "first misqualified", first, 4);
        cyc(4'b0001, 1, 0, 12'h300, 0, 1, 0);
        idle(1);

        // R6 multiple select
        do_reset();
        cur_req = "R6";
        cyc(4'b0011, 0, 0, 12'h400, 0, 0, 0);
        chk("R6", "flags multi", flags, 5'b10000);
        chk("R6", "first multi", first, 5);
        idle(1);

        // R9 pulse timing
        do_reset();
        cur_req = "R9";
        idle(1);
        cyc(4'b0100, 1, 0, 12'h500, 0, 1, 0);
        chk("R9", "pulse after violation", pulse, 1);
        idle(1);
        chk("R9", "pulse one cycle later", pulse, 0);

        // R8 sticky under legal traffic
        cur_req = "R8";
        xfer(4'b0001, 1, 12'h600, 32'h7, 1, 0);
        xfer(4'b0001, 0, 12'h604, 0, 0, 0);
        idle(3);
        chk("R8", "flags held", flags, 5'b00001);
        chk("R8", "first held", first, 1);

        // R10 simultaneous violations then later one
        do_reset();
        cur_req = "R10";
        cyc(4'b0011, 1, 0, 12'h700, 0, 0, 1);
        chk("R10", "flags simultaneous", flags, 5'b11001);
        chk("R10", "first lowest", first, 1);
        do_reset();
        cyc(4'b0001, 0, 0, 12'h700, 0, 0, 0);
        cyc(4'b0001, 1, 0, 12'h700, 0, 0, 1);
        cyc(4'b0001, 1, 0, 12'h700, 0, 1, 0);
        cyc(4'b0001, 1, 0, 12'h700, 0, 0, 0);
        chk("R10", "first keeps earliest", first, 4);
        chk("R10", "flags both", flags, 5'b01100);
        idle(1);

        // R1 reset clears
        cur_req = "R1";
        do_reset();
        chk("R1", "flags cleared", flags, 0);
        chk("R1", "first cleared", first, 0);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule